// File: doc/BRIEF.md
# Program Counter Range Profiler

This block counts retired instructions by code address. Each cycle the core may present one retired program counter with a valid strobe. The block compares that address against eight programmable code ranges and bumps the counter of every range it lands in. Software programs the bounds, chooses the counting mode, starts and stops profiling, and reads the counters back one at a time through a registered read port.

There are two counting modes. In overlap mode an address counts in every range that contains it. In exclusive mode only the matching range with the lowest index counts. A global address window sits in front of both modes, so addresses outside it never count. A one-cycle clear command zeroes the whole counter bank. The counters stop at their maximum value and do not wrap.

Configuration is written through a single port. A select code picks the item: 0 for a range lower bound, 1 for a range upper bound, 2 for the window lower bound, 3 for the window upper bound, and 4 for the mode, where data bit 0 set to 1 means overlap. The index input picks the range for codes 0 and 1. All bounds are inclusive.

Top module: `pc_range_profiler`

## Requirements
- R1: After reset all counters read 0, profiling is stopped, the mode is exclusive, every range is empty (lower bound all ones, upper bound 0), and the window covers the whole address space.
- R2: A retired address counts only while profiling is running. A start pulse begins profiling and a stop pulse ends it. When both arrive in the same cycle, stop wins.
- R3: In overlap mode (mode bit 1), a counted address increments every range whose bounds contain it, each by exactly one.
- R4: In exclusive mode (mode bit 0), a counted address increments only the lowest-indexed range that contains it.
- R5: An address below the window lower bound or above the window upper bound changes no counter.
- R6: Range and window bounds are inclusive: an address equal to either bound matches, and an address one past either bound does not.
- R7: A counter at its maximum value (all ones) stays there on further hits.
- R8: A clear pulse sets every counter to 0 at the next clock edge. A hit reaching the counters at that same edge is discarded.
- R9: rd_data shows the counter chosen by rd_idx one clock after rd_idx is applied. A retired address reaches its counter two clocks after it is presented.
- R10: A cycle with ret_valid low changes no counter, whatever ret_pc holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Item select: 0 range low, 1 range high, 2 window low, 3 window high, 4 mode |
| cfg_idx | input | 3 | Range index for select codes 0 and 1 |
| cfg_data | input | 32 | Bound value, or mode in bit 0 |
| cmd_start | input | 1 | Start profiling pulse |
| cmd_stop | input | 1 | Stop profiling pulse |
| cmd_clear | input | 1 | Clear all counters pulse |
| ret_valid | input | 1 | A retired instruction is presented this cycle |
| ret_pc | input | 32 | Address of the retired instruction |
| rd_idx | input | 3 | Counter to read |
| rd_data | output | 32 | Registered counter value |

## Verification
The assertions assume that the retire strobe, the commands and the configuration writes are all sampled synchronously and that nothing is still in flight across reset. The exclusive-mode check expects at most one hit per cycle. Counters are taken to move by at most one per edge, apart from clears. The stimulus changes configuration, mode and the start and stop state only while no retired address is in the two-stage path. It also waits for that path to drain before each read, so the scoreboard's expected values stay exact. The bench builds the block with 8-bit counters so that saturation can be reached in a few hundred retires.

// File: rtl/pcprof_pkg.sv
package pcprof_pkg;
  typedef enum logic [2:0] {
    SEL_RLO  = 3'd0,
    SEL_RHI  = 3'd1,
    SEL_WLO  = 3'd2,
    SEL_WHI  = 3'd3,
    SEL_MODE = 3'd4
  } cfg_sel_e;
endpackage

// File: rtl/pcprof_cfg.sv
module pcprof_cfg
  import pcprof_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 3
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 we_i,
  input  cfg_sel_e                             sel_i,
  input  logic [IDX_W-1:0]                     idx_i,
  input  logic [ADDR_W-1:0]                    data_i,
  output logic [NUM_RANGES-1:0][ADDR_W-1:0]    lo_o,
  output logic [NUM_RANGES-1:0][ADDR_W-1:0]    hi_o,
  output logic [ADDR_W-1:0]                    win_lo_o,
  output logic [ADDR_W-1:0]                    win_hi_o,
  output logic                                 overlap_o
);

  // Range bounds: reset to an empty interval (low above high)
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_RANGES; i++) begin
        lo_o[i] <= '1;
        hi_o[i] <= '0;
      end
    end else if (we_i) begin
      for (int i = 0; i < NUM_RANGES; i++) begin
        if (idx_i == IDX_W'(i)) begin
          if (sel_i == SEL_RLO) lo_o[i] <= data_i;
          if (sel_i == SEL_RHI) hi_o[i] <= data_i;
        end
      end
    end
  end

  // Global window and mode
  always_ff @(posedge clk) begin
    if (rst) begin
      win_lo_o  <= '0;
      win_hi_o  <= '1;
      overlap_o <= 1'b0;
    end else if (we_i) begin
      case (sel_i)
        SEL_WLO:  win_lo_o  <= data_i;
        SEL_WHI:  win_hi_o  <= data_i;
        SEL_MODE: overlap_o <= data_i[0];
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/pcprof_match.sv
module pcprof_match #(
  parameter int NUM_RANGES = 8,
  parameter int ADDR_W     = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              valid_i,
  input  logic [ADDR_W-1:0]                 pc_i,
  input  logic                              active_i,
  input  logic                              overlap_i,
  input  logic [NUM_RANGES-1:0][ADDR_W-1:0] lo_i,
  input  logic [NUM_RANGES-1:0][ADDR_W-1:0] hi_i,
  input  logic [ADDR_W-1:0]                 win_lo_i,
  input  logic [ADDR_W-1:0]                 win_hi_i,
  output logic [NUM_RANGES-1:0]             hit_q
);

  logic [NUM_RANGES-1:0] raw;
  logic [NUM_RANGES-1:0] pick;
  logic                  in_win;
  logic                  qualify;

  generate
    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_cmp
      assign raw[i] = (pc_i >= lo_i[i]) && (pc_i <= hi_i[i]);
    end
  endgenerate

  assign in_win  = (pc_i >= win_lo_i) && (pc_i <= win_hi_i);
  assign qualify = valid_i && active_i && in_win;

  // Exclusive mode keeps only the lowest set bit
  assign pick = overlap_i ? raw : (raw & (~raw + NUM_RANGES'(1)));

  always_ff @(posedge clk) begin
    if (rst) hit_q <= '0;
    else     hit_q <= qualify ? pick : '0;
  end

  p_exclusive_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    !overlap_i |=> $onehot0(hit_q));

  p_outside_window_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_i && ((pc_i < win_lo_i) || (pc_i > win_hi_i))) |=> (hit_q == '0));

  p_stopped_no_hit_r2: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> (hit_q == '0));

  p_invalid_no_hit_r10: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (hit_q == '0));

endmodule

// File: rtl/pcprof_counters.sv
module pcprof_counters #(
  parameter int NUM_RANGES = 8,
  parameter int CNT_W      = 32,
  parameter int IDX_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr_i,
  input  logic [NUM_RANGES-1:0] inc_i,
  input  logic [IDX_W-1:0]      rd_idx_i,
  output logic [CNT_W-1:0]      rd_data_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt [NUM_RANGES];

  // All counters may step in one cycle, so the bank lives in registers
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      for (int i = 0; i < NUM_RANGES; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_RANGES; i++) begin
        if (inc_i[i] && (cnt[i] != CNT_MAX)) cnt[i] <= cnt[i] + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                             rd_data_o <= '0;
    else if (int'(rd_idx_i) < NUM_RANGES) rd_data_o <= cnt[rd_idx_i];
    else                                  rd_data_o <= '0;
  end

  generate
    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_chk
      p_hold_max_r7: assert property (@(posedge clk) disable iff (rst)
        ((cnt[i] == CNT_MAX) && !clr_i) |=> (cnt[i] == CNT_MAX));

      p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt[i] == '0));

      p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((cnt[i] == $past(cnt[i])) ||
                    (cnt[i] == $past(cnt[i]) + CNT_W'(1))));
    end
  endgenerate

endmodule

// File: rtl/pc_range_profiler.sv
module pc_range_profiler
  import pcprof_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 32,
  localparam int IDX_W     = $clog2(NUM_RANGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_clear,
  input  logic              ret_valid,
  input  logic [ADDR_W-1:0] ret_pc,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CNT_W-1:0]  rd_data
);

  cfg_sel_e                          sel_e;
  logic [NUM_RANGES-1:0][ADDR_W-1:0] lo;
  logic [NUM_RANGES-1:0][ADDR_W-1:0] hi;
  logic [ADDR_W-1:0]                 win_lo;
  logic [ADDR_W-1:0]                 win_hi;
  logic                              overlap;
  logic                              active_q;
  logic [NUM_RANGES-1:0]             hit_q;

  assign sel_e = cfg_sel_e'(cfg_sel);

  // Run state: stop takes precedence over start
  always_ff @(posedge clk) begin
    if (rst)            active_q <= 1'b0;
    else if (cmd_stop)  active_q <= 1'b0;
    else if (cmd_start) active_q <= 1'b1;
  end

  pcprof_cfg #(
    .NUM_RANGES(NUM_RANGES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .we_i(cfg_we), .sel_i(sel_e), .idx_i(cfg_idx),
    .data_i(cfg_data), .lo_o(lo), .hi_o(hi), .win_lo_o(win_lo),
    .win_hi_o(win_hi), .overlap_o(overlap)
  );

  pcprof_match #(
    .NUM_RANGES(NUM_RANGES), .ADDR_W(ADDR_W)
  ) u_match (
    .clk(clk), .rst(rst), .valid_i(ret_valid), .pc_i(ret_pc),
    .active_i(active_q), .overlap_i(overlap), .lo_i(lo), .hi_i(hi),
    .win_lo_i(win_lo), .win_hi_i(win_hi), .hit_q(hit_q)
  );

  pcprof_counters #(
    .NUM_RANGES(NUM_RANGES), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .clr_i(cmd_clear), .inc_i(hit_q),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

endmodule

// File: tb/tb_pc_range_profiler.sv
module tb_pc_range_profiler;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 8;
  localparam int AW = 32;
  localparam int CW = 8;
  localparam int IW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_we, cmd_start, cmd_stop, cmd_clear, ret_valid;
  logic [2:0]    cfg_sel;
  logic [IW-1:0] cfg_idx, rd_idx;
  logic [AW-1:0] cfg_data, ret_pc;
  logic [CW-1:0] rd_data;

  pc_range_profiler #(.NUM_RANGES(NR), .ADDR_W(AW), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .cmd_clear(cmd_clear), .ret_valid(ret_valid),
    .ret_pc(ret_pc), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference model
  logic [AW-1:0] m_lo [NR];
  logic [AW-1:0] m_hi [NR];
  logic [AW-1:0] m_wlo, m_whi;
  bit            m_ovl, m_act;
  int            m_cnt [NR];

  // Scoreboard
  int    sb_idx [$];
  int    sb_exp [$];
  int    sb_due [$];
  string sb_tag [$];

  task automatic strobes_off();
    cfg_we = 0; cmd_start = 0; cmd_stop = 0; cmd_clear = 0; ret_valid = 0;
  endtask

  task automatic cfg_write(input int sel, input int idx, input logic [AW-1:0] d);
    @(negedge clk); strobes_off();
    cfg_we = 1; cfg_sel = 3'(sel); cfg_idx = IW'(idx); cfg_data = d;
    case (sel)
      0: m_lo[idx] = d;
      1: m_hi[idx] = d;
      2: m_wlo = d;
      3: m_whi = d;
      4: m_ovl = d[0];
      default: ;
    endcase
  endtask

  task automatic command(input bit st, input bit sp, input bit cl);
    @(negedge clk); strobes_off();
    cmd_start = st; cmd_stop = sp; cmd_clear = cl;
    if (sp) m_act = 0; else if (st) m_act = 1;
    if (cl) for (int i = 0; i < NR; i++) m_cnt[i] = 0;
  endtask

  task automatic model_hit(input logic [AW-1:0] pc);
    bit taken = 0;
    if (m_act && pc >= m_wlo && pc <= m_whi) begin
      for (int i = 0; i < NR; i++) begin
        if (pc >= m_lo[i] && pc <= m_hi[i] && (m_ovl || !taken)) begin
          taken = 1;
          if (m_cnt[i] < CMAX) m_cnt[i]++;
        end
      end
    end
  endtask

  task automatic retire(input logic [AW-1:0] pc);
    @(negedge clk); strobes_off();
    ret_valid = 1; ret_pc = pc;
    model_hit(pc);
  endtask

  task automatic settle();
    @(negedge clk); strobes_off();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read(input int idx, input string tag);
    @(negedge clk); strobes_off();
    rd_idx = IW'(idx);
    sb_idx.push_back(idx); sb_exp.push_back(m_cnt[idx]);
    sb_due.push_back(cyc + 1); sb_tag.push_back(tag);
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < NR; i++) do_read(i, tag);
  endtask

  // Monitor: compares each read once its result is registered
  initial begin
    forever begin
      @(negedge clk);
      if (sb_due.size() > 0 && sb_due[0] <= cyc) begin
        checks++;
        if (int'(rd_data) != sb_exp[0]) begin
          errors++;
          $display("FAIL %s idx %0d: actual %0d expected %0d",
                   sb_tag[0], sb_idx[0], rd_data, sb_exp[0]);
        end
        void'(sb_idx.pop_front()); void'(sb_exp.pop_front());
        void'(sb_due.pop_front()); void'(sb_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; strobes_off(); cfg_sel = 0; cfg_idx = 0; cfg_data = 0;
    ret_pc = 0; rd_idx = 0;
    for (int i = 0; i < NR; i++) begin m_lo[i] = '1; m_hi[i] = '0; m_cnt[i] = 0; end
    m_wlo = '0; m_whi = '1; m_ovl = 0; m_act = 0;
    repeat (4) @(negedge clk);
    rst = 0;

    // R1: reset counters, empty ranges even while running
    read_all("R1 reset counters");
    command(1, 0, 0);
    retire(32'h0); retire(32'hFFFF_FFFF); retire(32'h1234);
    settle();
    read_all("R1 empty ranges");

    // R2: no counting while stopped
    command(0, 1, 0);
    cfg_write(0, 0, 32'h100); cfg_write(1, 0, 32'h1FF);
    retire(32'h150);
    settle();
    do_read(0, "R2 stopped");

    // R6: inclusive bounds, R9 read latency
    command(1, 0, 0);
    retire(32'h100); retire(32'h1FF); retire(32'hFF); retire(32'h200);
    settle();
    do_read(0, "R6 inclusive bounds");
    do_read(1, "R9 neighbour read");

    // R3: overlap mode
    cfg_write(0, 1, 32'h180); cfg_write(1, 1, 32'h2FF);
    cfg_write(0, 2, 32'h0);   cfg_write(1, 2, 32'hFFF);
    cfg_write(4, 0, 32'h1);
    retire(32'h190); retire(32'h250);
    settle();
    for (int i = 0; i < 3; i++) do_read(i, "R3 overlap");

    // R4: exclusive mode, lowest index wins
    cfg_write(4, 0, 32'h0);
    retire(32'h190); retire(32'h250); retire(32'h800); retire(32'h190);
    settle();
    for (int i = 0; i < 3; i++) do_read(i, "R4 exclusive");

    // R5 and R6: window gating at its bounds
    cfg_write(2, 0, 32'h180); cfg_write(3, 0, 32'h7FF);
    retire(32'h150); retire(32'h800); retire(32'h17F);
    retire(32'h180); retire(32'h7FF); retire(32'h190);
    settle();
    for (int i = 0; i < 3; i++) do_read(i, "R5 window");

    // R10: valid low with an in-range address
    @(negedge clk); strobes_off(); ret_pc = 32'h190;
    repeat (5) @(negedge clk);
    settle();
    for (int i = 0; i < 3; i++) do_read(i, "R10 valid low");

    // R2: stop, and stop winning over start
    command(0, 1, 0);
    retire(32'h190);
    command(1, 1, 0);
    retire(32'h190);
    settle();
    do_read(0, "R2 stop wins");
    command(1, 0, 0);
    retire(32'h190);
    settle();
    do_read(0, "R2 restart");

    // R8: clear, then clear beating an in-flight hit
    command(0, 0, 1);
    settle();
    read_all("R8 clear");
    retire(32'h190);
    command(0, 0, 1);
    settle();
    do_read(0, "R8 clear wins");
    retire(32'h190);
    settle();
    do_read(0, "R8 count after clear");

    // R7: saturation
    cfg_write(2, 0, 32'h0); cfg_write(3, 0, 32'hFFFF_FFFF);
    for (int k = 0; k < CMAX + 20; k++) retire(32'h100);
    settle();
    do_read(0, "R7 saturate");
    do_read(2, "R7 other counter");
    retire(32'h100); retire(32'h120);
    settle();
    do_read(0, "R7 hold at max");

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule